// File: doc/BRIEF.md
# Eight-Pin I/O Port with Edge Interrupts

This block controls one port of eight general-purpose pins. Software reaches it through a flat register interface: a write strobe with an address and data, plus a read address with a combinational read result. Each pin keeps an output data bit. The bit can be loaded directly, or changed by set, clear and toggle writes that act only on the bits written as 1. Each pin also keeps a four-bit drive mode. The block turns this mode into pad controls: output enable, pull-up enable, pull-down enable and input-buffer enable.

The pin inputs pass through a two-flop synchronizer and then an edge detector. Each pin has its own edge selector, and a detected edge latches a per-pin status bit. A ninth source takes any one pin through a glitch filter that needs two equal consecutive samples, and it has its own edge selector. Status bits can be cleared or forced by writes. A nine-bit mask gates them onto a single port interrupt line. The register interface carries configuration and status rather than a data stream, so it has no valid/ready handshake. Every write takes effect at the clock edge where `wr_en` is high.

Register addresses (4 bits): 0 output data, 1 set, 2 clear, 3 toggle, 4 drive mode, 5 edge configuration, 6 mask, 7 status (write 1 to clear), 8 force, 9 masked status (read only), 10 synchronized pin levels (read only). Any other address reads 0.

Top module: `gpio_edge_port`

## Requirements
- R1: After reset, every readable register reads 0 and `pad_out`, `pad_oe`, `pad_pu`, `pad_pd`, `pad_ie` and `irq` are 0.
- R2: Pin n's output bit is bit n of every per-pin field. A write to address 0 loads the output data. Writes to addresses 1, 2 and 3 set, clear and toggle only the pins whose written bit is 1. `pad_out` shows the output data.
- R3: Address 4 holds pin n's drive mode in bits [4n+3:4n]. Bit 3 of a pin's mode drives that pin's `pad_ie`.
- R4: A drive-mode write whose field for a pin is 1 or 9 leaves that pin's stored mode unchanged. The other pins in the same write still update.
- R5: The low three mode bits decode with output data d as follows. 0: all controls off. 2: d=1 gives pull-up, d=0 gives output enable. 3: d=0 gives pull-down, d=1 gives output enable. 4: output enable only when d=0. 5: output enable only when d=1. 6: output enable always. 7: d=1 gives pull-up, d=0 gives pull-down.
- R6: Address 5 bits [2n+1:2n] set pin n's edge selection: 0 none, 1 rising, 2 falling, 3 both. A qualifying change on `pin_in[n]` set up before clock edge k makes status bit n read 1 after edge k+2, and not after edge k+1.
- R7: Address 5 bits [20:18] pick the pin for the filtered source, and bits [17:16] give its edge selection with the same encoding. Status bit 8 is set only after the selected synchronized level holds two consecutive samples (readable after edge k+3). A one-cycle pulse never sets it.
- R8: Writing 1 to a bit at address 7 clears that status bit, and a status bit otherwise holds its value. A new edge in the same cycle as the clear wins, so the bit stays 1.
- R9: Writing 1 to a bit at address 8 sets that status bit.
- R10: Address 6 holds a 9-bit mask. Address 9 reads status AND mask. `irq` is 1 exactly when some masked status bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 4 | Read address |
| rd_data | output | 32 | Combinational read data |
| pin_in | input | 8 | Asynchronous pin levels |
| pad_out | output | 8 | Output data toward the pads |
| pad_oe | output | 8 | Active output drive per pin |
| pad_pu | output | 8 | Resistive pull-up enable per pin |
| pad_pd | output | 8 | Resistive pull-down enable per pin |
| pad_ie | output | 8 | Digital input buffer enable per pin |
| irq | output | 1 | Port interrupt |

## Verification
Pad decoding is driven by random drive-mode words. Each nibble comes from all sixteen codes, so legal codes are told apart from the rejected codes 1 and 9, and random output data shows both data-dependent branches of every mode. Edge detection uses random edge selections and random pin transitions, which tells rising, falling and both-edge selection apart on each pin and on the filtered source. Directed cases cover the exact cycle a status bit appears, a one-cycle glitch against a held level on the filtered pin, and a clear that meets a new edge against a clear with no edge. Random masks and forced status patterns show which sources reach `irq`.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] ADR_DATA  = 4'd0;
  localparam logic [ADDR_W-1:0] ADR_SET   = 4'd1;
  localparam logic [ADDR_W-1:0] ADR_CLR   = 4'd2;
  localparam logic [ADDR_W-1:0] ADR_TGL   = 4'd3;
  localparam logic [ADDR_W-1:0] ADR_MODE  = 4'd4;
  localparam logic [ADDR_W-1:0] ADR_EDGE  = 4'd5;
  localparam logic [ADDR_W-1:0] ADR_MASK  = 4'd6;
  localparam logic [ADDR_W-1:0] ADR_STAT  = 4'd7;
  localparam logic [ADDR_W-1:0] ADR_FORCE = 4'd8;
  localparam logic [ADDR_W-1:0] ADR_MSTAT = 4'd9;
  localparam logic [ADDR_W-1:0] ADR_LEVEL = 4'd10;

  // Low three bits of a drive mode; bit 3 (input buffer) is kept separately.
  typedef enum logic [2:0] {
    DRV_ANALOG = 3'd0,
    DRV_BAD    = 3'd1,
    DRV_PULLUP = 3'd2,
    DRV_PULLDN = 3'd3,
    DRV_ODLOW  = 3'd4,
    DRV_ODHIGH = 3'd5,
    DRV_STRONG = 3'd6,
    DRV_PUPD   = 3'd7
  } drv_kind_e;

  // Edge selector: bit 0 enables rising, bit 1 enables falling.
  function automatic logic edge_hit(input logic [1:0] cfg, input logic r, input logic f);
    return (cfg[0] & r) | (cfg[1] & f);
  endfunction
endpackage

// File: rtl/gpio_pad_decode.sv
module gpio_pad_decode
  import gpio_port_pkg::*;
(
  input  logic [2:0] kind,
  input  logic       dat,
  output logic       oe,
  output logic       pu,
  output logic       pd
);
  always_comb begin
    oe = 1'b0;
    pu = 1'b0;
    pd = 1'b0;
    case (drv_kind_e'(kind))
      DRV_PULLUP: begin pu = dat;  oe = ~dat; end
      DRV_PULLDN: begin pd = ~dat; oe = dat;  end
      DRV_ODLOW:  oe = ~dat;
      DRV_ODHIGH: oe = dat;
      DRV_STRONG: oe = 1'b1;
      DRV_PUPD:   begin pu = dat; pd = ~dat; end
      default:    ;
    endcase
  end
endmodule

// File: rtl/gpio_sync_edge.sv
module gpio_sync_edge #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] lvl,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [W-1:0] meta_q, sync_q, prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= din;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign lvl  = sync_q;
  assign rise = sync_q & ~prev_q;
  assign fall = ~sync_q & prev_q;
endmodule

// File: rtl/gpio_glitch_filter.sv
module gpio_glitch_filter (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise,
  output logic fall
);
  logic smp_q, lvl_q, steady;

  assign steady = (din == smp_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      smp_q <= 1'b0;
      lvl_q <= 1'b0;
    end else begin
      smp_q <= din;
      if (steady) lvl_q <= din;
    end
  end

  assign rise = steady & din & ~lvl_q;
  assign fall = steady & ~din & lvl_q;
endmodule

// File: rtl/gpio_edge_port.sv
module gpio_edge_port
  import gpio_port_pkg::*;
#(
  parameter int NPIN = 8,
  parameter int DW   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DW-1:0]     rd_data,
  input  logic [NPIN-1:0]   pin_in,
  output logic [NPIN-1:0]   pad_out,
  output logic [NPIN-1:0]   pad_oe,
  output logic [NPIN-1:0]   pad_pu,
  output logic [NPIN-1:0]   pad_pd,
  output logic [NPIN-1:0]   pad_ie,
  output logic              irq
);
  localparam int SELW  = $clog2(NPIN);
  localparam int NSRC  = NPIN + 1;
  localparam int MODEW = 4;
  localparam int FE_LO = 2 * NPIN;
  localparam int FS_LO = FE_LO + 2;

  logic [NPIN-1:0]             dat_q;
  logic [NPIN-1:0][MODEW-1:0]  mode_q;
  logic [2*NPIN-1:0]           edge_q;
  logic [1:0]                  fedge_q;
  logic [SELW-1:0]             fsel_q;
  logic [NSRC-1:0]             mask_q, stat_q, hits, clr_v, frc_v;
  logic [NPIN-1:0]             lvl, rise, fall;
  logic                        frise, ffall;

  function automatic logic hit(input logic [ADDR_W-1:0] a);
    return wr_en && (wr_addr == a);
  endfunction

  // Output data and its bitwise modifiers
  always_ff @(posedge clk) begin
    if (!rst_n) dat_q <= '0;
    else if (wr_en) begin
      case (wr_addr)
        ADR_DATA: dat_q <= wr_data[NPIN-1:0];
        ADR_SET:  dat_q <= dat_q | wr_data[NPIN-1:0];
        ADR_CLR:  dat_q <= dat_q & ~wr_data[NPIN-1:0];
        ADR_TGL:  dat_q <= dat_q ^ wr_data[NPIN-1:0];
        default:  ;
      endcase
    end
  end
  assign pad_out = dat_q;

  // Per-pin drive mode storage and pad decode
  for (genvar p = 0; p < NPIN; p++) begin : g_pin
    logic [MODEW-1:0] fld;
    assign fld = wr_data[MODEW*p +: MODEW];

    always_ff @(posedge clk) begin
      if (!rst_n) mode_q[p] <= '0;
      else if (hit(ADR_MODE) && (fld[2:0] != DRV_BAD)) mode_q[p] <= fld;
    end

    gpio_pad_decode u_dec (
      .kind (mode_q[p][2:0]),
      .dat  (dat_q[p]),
      .oe   (pad_oe[p]),
      .pu   (pad_pu[p]),
      .pd   (pad_pd[p])
    );
    assign pad_ie[p] = mode_q[p][MODEW-1];
    assign hits[p]   = edge_hit(edge_q[2*p +: 2], rise[p], fall[p]);
  end

  // Interrupt configuration
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      edge_q  <= '0;
      fedge_q <= '0;
      fsel_q  <= '0;
      mask_q  <= '0;
    end else begin
      if (hit(ADR_EDGE)) begin
        edge_q  <= wr_data[FE_LO-1:0];
        fedge_q <= wr_data[FE_LO +: 2];
        fsel_q  <= wr_data[FS_LO +: SELW];
      end
      if (hit(ADR_MASK)) mask_q <= wr_data[NSRC-1:0];
    end
  end

  gpio_sync_edge #(.W(NPIN)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (pin_in),
    .lvl  (lvl),
    .rise (rise),
    .fall (fall)
  );

  gpio_glitch_filter u_flt (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (lvl[fsel_q]),
    .rise (frise),
    .fall (ffall)
  );
  assign hits[NPIN] = edge_hit(fedge_q, frise, ffall);

  // Status: clear first, then force and new edges win
  assign clr_v = hit(ADR_STAT)  ? wr_data[NSRC-1:0] : '0;
  assign frc_v = hit(ADR_FORCE) ? wr_data[NSRC-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= (stat_q & ~clr_v) | frc_v | hits;
  end

  assign irq = |(stat_q & mask_q);

  // Read mux
  always_comb begin
    rd_data = '0;
    case (rd_addr)
      ADR_DATA:  rd_data[NPIN-1:0] = dat_q;
      ADR_MODE:  rd_data[MODEW*NPIN-1:0] = mode_q;
      ADR_EDGE: begin
        rd_data[FE_LO-1:0]     = edge_q;
        rd_data[FE_LO +: 2]    = fedge_q;
        rd_data[FS_LO +: SELW] = fsel_q;
      end
      ADR_MASK:  rd_data[NSRC-1:0] = mask_q;
      ADR_STAT:  rd_data[NSRC-1:0] = stat_q;
      ADR_MSTAT: rd_data[NSRC-1:0] = stat_q & mask_q;
      ADR_LEVEL: rd_data[NPIN-1:0] = lvl;
      default:   ;
    endcase
  end
endmodule

// File: rtl/gpio_edge_port_chk.sv
module gpio_edge_port_chk
  import gpio_port_pkg::*;
#(
  parameter int NPIN = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                wr_en,
  input logic [ADDR_W-1:0]   wr_addr,
  input logic [NPIN:0]       wr_lo,
  input logic [NPIN-1:0]     pad_out,
  input logic [NPIN-1:0]     pad_oe,
  input logic [NPIN-1:0]     pad_pu,
  input logic [NPIN-1:0]     pad_pd,
  input logic [NPIN:0]       stat,
  input logic [4*NPIN-1:0]   mode_flat
);
  logic [NPIN:0] clr_seen;
  assign clr_seen = (wr_en && wr_addr == ADR_STAT) ? wr_lo : '0;

  function automatic logic modes_legal(input logic [4*NPIN-1:0] m);
    logic ok = 1'b1;
    for (int i = 0; i < NPIN; i++) if (m[4*i +: 3] == 3'd1) ok = 1'b0;
    return ok;
  endfunction

  // R4: an illegal code never reaches a stored mode
  assert_mode_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
    modes_legal(mode_flat));

  // R2: set and clear writes act on the written pins
  assert_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ADR_SET) |=>
      ((pad_out & $past(wr_lo[NPIN-1:0])) == $past(wr_lo[NPIN-1:0])));

  assert_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ADR_CLR) |=> ((pad_out & $past(wr_lo[NPIN-1:0])) == '0));

  // R5: active drive never combined with a pull, and both pulls never together
  assert_pull_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_oe & (pad_pu | pad_pd)) == '0) && ((pad_pu & pad_pd) == '0));

  // R8: a status bit only drops after a clear write to it
  assert_stat_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(stat) & ~$past(clr_seen) & ~stat) == '0));

  // R9: forced bits read as set on the next cycle
  assert_force_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ADR_FORCE) |=> ((stat & $past(wr_lo)) == $past(wr_lo)));
endmodule

bind gpio_edge_port gpio_edge_port_chk #(.NPIN(NPIN)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_en    (wr_en),
  .wr_addr  (wr_addr),
  .wr_lo    (wr_data[NPIN:0]),
  .pad_out  (pad_out),
  .pad_oe   (pad_oe),
  .pad_pu   (pad_pu),
  .pad_pd   (pad_pd),
  .stat     (stat_q),
  .mode_flat(mode_q)
);

// File: tb/gpio_edge_port_test.sv
module gpio_edge_port_test;
  import gpio_port_pkg::*;
  localparam int CLK_NS = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [3:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic [7:0]  pin_in = '0;
  logic [7:0]  pad_out, pad_oe, pad_pu, pad_pd, pad_ie;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  gpio_edge_port uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .pin_in(pin_in), .pad_out(pad_out),
    .pad_oe(pad_oe), .pad_pu(pad_pu), .pad_pd(pad_pd), .pad_ie(pad_ie), .irq(irq)
  );

  task automatic chk(input string tag, input logic [39:0] act, input logic [39:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  // Expected pad controls {oe,pu,pd} from the drive-mode table
  function automatic logic [2:0] pad_exp(input logic [2:0] m, input logic d);
    case (m)
      3'd2: return d ? 3'b010 : 3'b100;
      3'd3: return d ? 3'b100 : 3'b001;
      3'd4: return d ? 3'b000 : 3'b100;
      3'd5: return d ? 3'b100 : 3'b000;
      3'd6: return 3'b100;
      3'd7: return d ? 3'b010 : 3'b001;
      default: return 3'b000;
    endcase
  endfunction

  function automatic logic [8:0] stat_exp(input logic [7:0] o, input logic [7:0] n,
                                          input logic [15:0] cfg, input logic [1:0] fe,
                                          input logic [2:0] fs);
    logic [8:0] s = '0;
    for (int i = 0; i < 8; i++)
      s[i] = (cfg[2*i] & n[i] & ~o[i]) | (cfg[2*i+1] & ~n[i] & o[i]);
    s[8] = (fe[0] & n[fs] & ~o[fs]) | (fe[1] & ~n[fs] & o[fs]);
    return s;
  endfunction

  task automatic pads_chk(input string tag, input logic [31:0] em, input logic [7:0] ed);
    logic [7:0] eo, eu, edn, ei;
    for (int p = 0; p < 8; p++) begin
      {eo[p], eu[p], edn[p]} = pad_exp(em[4*p +: 3], ed[p]);
      ei[p] = em[4*p+3];
    end
    chk(tag, {pad_out, pad_oe, pad_pu, pad_pd, pad_ie}, {ed, eo, eu, edn, ei});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog R1 actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] r, e_mode, v;
    logic [7:0]  e_dat, oldp, newp;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    for (int a = 0; a < 11; a++) begin
      rd(4'(a), r);
      chk("R1 register reset", {8'h0, r}, 40'h0);
    end
    chk("R1 pads and irq reset", {pad_out, pad_oe, pad_pu, pad_pd, pad_ie, 7'h0, irq}, 48'h0);

    // R2: directed data operations
    wr(ADR_DATA, 32'hA5);   chk("R2 load", {32'h0, pad_out}, 40'hA5);
    wr(ADR_SET, 32'h0F);    chk("R2 set",  {32'h0, pad_out}, 40'hAF);
    wr(ADR_CLR, 32'hA0);    chk("R2 clear", {32'h0, pad_out}, 40'h0F);
    wr(ADR_TGL, 32'h3C);    chk("R2 toggle", {32'h0, pad_out}, 40'h33);
    e_dat = 8'h33;

    // R4: directed illegal codes mixed with legal ones
    wr(ADR_MODE, 32'h66666666);
    wr(ADR_MODE, 32'h1919E9E1);
    e_mode = 32'h6666E6E6;
    rd(ADR_MODE, r);
    chk("R4 codes 1 and 9 ignored per pin", {8'h0, r}, {8'h0, e_mode});
    pads_chk("R4 pads after rejected codes", e_mode, e_dat);

    // R2 R3 R5: random data operations and drive modes
    for (int it = 0; it < 60; it++) begin
      logic [31:0] m;
      logic [2:0]  op;
      v = $urandom;
      op = 3'($urandom % 4);
      wr(4'(op), {24'h0, v[7:0]});
      case (op)
        3'd0: e_dat = v[7:0];
        3'd1: e_dat = e_dat | v[7:0];
        3'd2: e_dat = e_dat & ~v[7:0];
        default: e_dat = e_dat ^ v[7:0];
      endcase
      m = '0;
      for (int p = 0; p < 8; p++) m[4*p +: 4] = 4'($urandom % 16);
      wr(ADR_MODE, m);
      for (int p = 0; p < 8; p++)
        if (m[4*p +: 3] != 3'd1) e_mode[4*p +: 4] = m[4*p +: 4];
      rd(ADR_DATA, r);
      chk("R2 output data", {8'h0, r}, {32'h0, e_dat});
      rd(ADR_MODE, r);
      chk("R3 R4 mode readback", {8'h0, r}, {8'h0, e_mode});
      pads_chk("R5 R3 pad decode", e_mode, e_dat);
    end

    // R6: exact latency of a pin edge
    wr(ADR_EDGE, 32'h1);
    wr(ADR_STAT, 32'h1FF);
    @(negedge clk); pin_in = 8'h01;
    @(posedge clk); @(posedge clk); @(negedge clk);
    rd(ADR_STAT, r);
    chk("R6 not yet after edge k+1", {8'h0, r}, 40'h0);
    @(negedge clk);
    rd(ADR_STAT, r);
    chk("R6 set after edge k+2", {8'h0, r}, 40'h1);

    // R8: clear meets a new edge (both edges selected on pin 0)
    wr(ADR_EDGE, 32'h3);
    @(negedge clk); pin_in = 8'h00;
    @(posedge clk); @(posedge clk); @(negedge clk);
    wr_en = 1'b1; wr_addr = ADR_STAT; wr_data = 32'h1;
    @(negedge clk); wr_en = 1'b0;
    rd(ADR_STAT, r);
    chk("R8 edge wins over clear", {8'h0, r}, 40'h1);
    repeat (3) @(negedge clk);
    rd(ADR_STAT, r);
    chk("R8 status holds without clear", {8'h0, r}, 40'h1);
    wr(ADR_STAT, 32'h1);
    rd(ADR_STAT, r);
    chk("R8 clear without edge", {8'h0, r}, 40'h0);

    // R7: glitch against held level on filtered pin 3, rising
    wr(ADR_EDGE, (32'd3 << 18) | (32'd1 << 16));
    repeat (4) @(negedge clk);
    wr(ADR_STAT, 32'h1FF);
    pin_in = 8'h08;
    @(negedge clk); pin_in = 8'h00;
    repeat (8) @(negedge clk);
    rd(ADR_STAT, r);
    chk("R7 one-cycle pulse ignored", {8'h0, r}, 40'h0);
    pin_in = 8'h08;
    @(posedge clk); @(posedge clk); @(posedge clk); @(negedge clk);
    rd(ADR_STAT, r);
    chk("R7 not yet after edge k+2", {8'h0, r}, 40'h0);
    @(negedge clk);
    rd(ADR_STAT, r);
    chk("R7 held level sets bit 8", {8'h0, r}, 40'h100);
    oldp = 8'h08;

    // R6 R7: random edge configurations and transitions
    for (int it = 0; it < 40; it++) begin
      logic [15:0] cfg;
      logic [1:0]  fe;
      logic [2:0]  fs;
      cfg = 16'($urandom);
      fe = 2'($urandom % 4);
      fs = 3'($urandom % 8);
      wr(ADR_EDGE, {11'h0, fs, fe, cfg});
      repeat (4) @(negedge clk);
      wr(ADR_STAT, 32'h1FF);
      newp = 8'($urandom);
      pin_in = newp;
      repeat (6) @(negedge clk);
      rd(ADR_STAT, r);
      chk("R6 R7 random edge status", {8'h0, r}, {31'h0, stat_exp(oldp, newp, cfg, fe, fs)});
      rd(ADR_LEVEL, r);
      chk("R6 synchronized level", {8'h0, r}, {32'h0, newp});
      oldp = newp;
    end

    // R9 R10: forced status with random masks
    wr(ADR_EDGE, 32'h0);
    repeat (4) @(negedge clk);
    for (int it = 0; it < 20; it++) begin
      logic [8:0] fv, mk;
      fv = 9'($urandom);
      mk = 9'($urandom);
      if (it == 0) begin fv = 9'h100; mk = 9'h0FF; end
      if (it == 1) begin fv = 9'h100; mk = 9'h100; end
      wr(ADR_STAT, 32'h1FF);
      wr(ADR_MASK, {23'h0, mk});
      wr(ADR_FORCE, {23'h0, fv});
      rd(ADR_STAT, r);
      chk("R9 forced status", {8'h0, r}, {31'h0, fv});
      rd(ADR_MSTAT, r);
      chk("R10 masked status", {8'h0, r}, {31'h0, fv & mk});
      chk("R10 irq", {39'h0, irq}, {39'h0, |(fv & mk)});
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule